// File: doc/BRIEF.md
# Stage-Based Die Temperature Estimator

This block produces an estimate of die temperature, in millidegrees Celsius, for systems where only a coarse over-temperature stage indicator is available and no converter reading exists. A 2-bit stage input (0 means cool; 1 to 3 mean that successively hotter thresholds have been crossed) is sampled on a one-cycle strobe. The block compares the sampled stage with the stage it recorded at the previous sample. From the direction of the change it derives an estimate that sits just inside the temperature band of the new stage. When the stage rises, the estimate is placed a hysteresis offset above the band's lower edge. When the stage falls, it is placed the same offset below the band's upper edge. If the stage has not moved, the previous estimate is kept.

A 2-bit threshold select shifts the whole set of thresholds in 5000 m°C steps above a 105000 m°C floor. The block continuously drives the three trip temperatures and the critical temperature for the selected setting. An initialisation strobe seeds the estimate from the current stage alone, with no hysteresis term. The estimate is a 32-bit signed value and is never reported below zero.

Top module: `die_temp_estimator`

## Requirements
- R1: After reset, est_mc is 37000, rec_stage is 0 and stage_changed is 0.
- R2: With base = 105000 + 5000 × thr_sel, the trips_mc slice [31:0] (stage 1) is base, slice [63:32] (stage 2) is base + 20000, and slice [95:64] (stage 3) is base + 40000. crit_mc equals the stage-3 trip. All of these follow thr_sel combinationally.
- R3: In the cycle after init_strobe, est_mc is 37000 if stage_in was 0, and base + (stage_in − 1) × 20000 otherwise. rec_stage takes stage_in and stage_changed stays 0. init_strobe wins over a simultaneous sample_strobe.
- R4: In the cycle after a sample_strobe whose stage_in exceeds rec_stage, est_mc is (stage_in − 1) × 20000 + base + 2000.
- R5: In the cycle after a sample_strobe whose stage_in is below rec_stage, est_mc is stage_in × 20000 + base − 2000.
- R6: A sample_strobe whose stage_in equals rec_stage leaves est_mc unchanged, even if thr_sel has changed.
- R7: stage_changed is high for exactly the one cycle after a sample_strobe whose stage_in differs from rec_stage. Every sample_strobe loads rec_stage with stage_in.
- R8: In a cycle with no strobe, est_mc and rec_stage keep their values.
- R9: The estimate is clamped so that est_mc never shows a negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_strobe | input | 1 | Seed the estimate from the current stage |
| sample_strobe | input | 1 | Sample the stage and update the estimate |
| stage_in | input | 2 | Current over-temperature stage |
| thr_sel | input | 2 | Threshold select |
| est_mc | output | 32 | Signed temperature estimate in m°C |
| rec_stage | output | 2 | Stage recorded at the last strobe |
| stage_changed | output | 1 | One-cycle pulse after a stage change |
| trips_mc | output | 96 | Trip temperatures for stages 1 to 3, 32 bits each |
| crit_mc | output | 32 | Critical temperature |

## Verification
A wrong recorded stage does not show up as a wrong value on its own. It shows up at the next sample: the direction decision is taken against the wrong reference, so est_mc moves by the wrong formula, or is held when it should move, and stage_changed pulses at the wrong time. Both effects appear one cycle after that strobe. A corrupted estimate register appears on est_mc at once and stays there until the next stage change overwrites it, so each hold case compares est_mc with the value computed at the last move. The sweep runs every threshold select against every pair of previous and new stage, which covers every direction from every starting band.

// File: rtl/temp_est_pkg.sv
package temp_est_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_RISE = 2'd1,
    DIR_FALL = 2'd2
  } dir_e;

  // Lower threshold shifted by the select value.
  function automatic longint base_of(longint sel, longint floor_mc, longint sel_step);
    return floor_mc + sel * sel_step;
  endfunction

  // Lower edge of the band for a stage of 1 or more.
  function automatic longint trip_of(longint stage, longint base, longint step);
    return base + (stage - 1) * step;
  endfunction

  // Entering a hotter band: just above its lower edge.
  function automatic longint rise_est(longint stage, longint base, longint step, longint hyst);
    return trip_of(stage, base, step) + hyst;
  endfunction

  // Entering a cooler band: just below its upper edge.
  function automatic longint fall_est(longint stage, longint base, longint step, longint hyst);
    return base + stage * step - hyst;
  endfunction

  // Seed value: idle temperature at stage 0, otherwise the band's lower edge.
  function automatic longint init_est(longint stage, longint base, longint step, longint idle);
    return (stage == 0) ? idle : trip_of(stage, base, step);
  endfunction

  function automatic longint clamp_nonneg(longint v);
    return (v < 0) ? 64'sd0 : v;
  endfunction

endpackage

// File: rtl/temp_est_trip.sv
module temp_est_trip
  import temp_est_pkg::*;
#(
  parameter int     SEL_W         = 2,
  parameter int     STAGE_W       = 2,
  parameter int     TEMP_W        = 32,
  parameter longint FLOOR_MC      = 105000,
  parameter longint SEL_STEP_MC   = 5000,
  parameter longint STAGE_STEP_MC = 20000
) (
  input  logic [SEL_W-1:0]                          thr_sel,
  output logic [((1<<STAGE_W)-1)*TEMP_W-1:0]        trips_mc
);

  localparam int N_TRIP = (1 << STAGE_W) - 1;

  longint base_l;
  assign base_l = base_of(longint'(thr_sel), FLOOR_MC, SEL_STEP_MC);

  for (genvar k = 0; k < N_TRIP; k++) begin : g_trip
    longint trip_l;
    assign trip_l = clamp_nonneg(trip_of(longint'(k + 1), base_l, STAGE_STEP_MC));
    assign trips_mc[k*TEMP_W +: TEMP_W] = TEMP_W'(trip_l);
  end

endmodule

// File: rtl/temp_est_dir.sv
module temp_est_dir
  import temp_est_pkg::*;
#(
  parameter int STAGE_W = 2
) (
  input  logic [STAGE_W-1:0] stage_in,
  input  logic [STAGE_W-1:0] rec_stage,
  output dir_e               dir,
  output logic               differs
);

  always_comb begin
    if (stage_in > rec_stage)      dir = DIR_RISE;
    else if (stage_in < rec_stage) dir = DIR_FALL;
    else                           dir = DIR_HOLD;
  end

  assign differs = (dir != DIR_HOLD);

endmodule

// File: rtl/temp_est_next.sv
module temp_est_next
  import temp_est_pkg::*;
#(
  parameter int     SEL_W         = 2,
  parameter int     STAGE_W       = 2,
  parameter int     TEMP_W        = 32,
  parameter longint FLOOR_MC      = 105000,
  parameter longint SEL_STEP_MC   = 5000,
  parameter longint STAGE_STEP_MC = 20000,
  parameter longint HYST_MC       = 2000,
  parameter longint IDLE_MC       = 37000
) (
  input  logic               init_go,
  input  dir_e               dir,
  input  logic [STAGE_W-1:0] stage_in,
  input  logic [SEL_W-1:0]   thr_sel,
  input  logic [TEMP_W-1:0]  est_q,
  output logic [TEMP_W-1:0]  est_d
);

  longint base_l;
  longint stage_l;
  longint cand_l;

  assign base_l  = base_of(longint'(thr_sel), FLOOR_MC, SEL_STEP_MC);
  assign stage_l = longint'(stage_in);

  always_comb begin
    cand_l = 64'sd0;
    if (init_go) begin
      cand_l = init_est(stage_l, base_l, STAGE_STEP_MC, IDLE_MC);
    end else begin
      case (dir)
        DIR_RISE: cand_l = rise_est(stage_l, base_l, STAGE_STEP_MC, HYST_MC);
        DIR_FALL: cand_l = fall_est(stage_l, base_l, STAGE_STEP_MC, HYST_MC);
        default:  cand_l = 64'sd0;
      endcase
    end
  end

  always_comb begin
    if (!init_go && dir == DIR_HOLD) est_d = est_q;
    else                             est_d = TEMP_W'(clamp_nonneg(cand_l));
  end

endmodule

// File: rtl/die_temp_estimator.sv
module die_temp_estimator
  import temp_est_pkg::*;
#(
  parameter int     SEL_W         = 2,
  parameter int     STAGE_W       = 2,
  parameter int     TEMP_W        = 32,
  parameter longint FLOOR_MC      = 105000,
  parameter longint SEL_STEP_MC   = 5000,
  parameter longint STAGE_STEP_MC = 20000,
  parameter longint HYST_MC       = 2000,
  parameter longint IDLE_MC       = 37000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   init_strobe,
  input  logic                                   sample_strobe,
  input  logic [STAGE_W-1:0]                     stage_in,
  input  logic [SEL_W-1:0]                       thr_sel,
  output logic [TEMP_W-1:0]                      est_mc,
  output logic [STAGE_W-1:0]                     rec_stage,
  output logic                                   stage_changed,
  output logic [((1<<STAGE_W)-1)*TEMP_W-1:0]     trips_mc,
  output logic [TEMP_W-1:0]                      crit_mc
);

  localparam int N_TRIP = (1 << STAGE_W) - 1;

  logic [TEMP_W-1:0]  est_q;
  logic [TEMP_W-1:0]  est_d;
  logic [STAGE_W-1:0] rec_q;
  logic               chg_q;
  dir_e               dir;
  logic               differs;
  logic               load_en;
  logic               sample_go;

  // Named events: any strobe loads, a sample without init may pulse.
  assign load_en   = init_strobe | sample_strobe;
  assign sample_go = sample_strobe & ~init_strobe;

  temp_est_dir #(.STAGE_W(STAGE_W)) u_dir (
    .stage_in (stage_in),
    .rec_stage(rec_q),
    .dir      (dir),
    .differs  (differs)
  );

  temp_est_next #(
    .SEL_W(SEL_W), .STAGE_W(STAGE_W), .TEMP_W(TEMP_W),
    .FLOOR_MC(FLOOR_MC), .SEL_STEP_MC(SEL_STEP_MC),
    .STAGE_STEP_MC(STAGE_STEP_MC), .HYST_MC(HYST_MC), .IDLE_MC(IDLE_MC)
  ) u_next (
    .init_go (init_strobe),
    .dir     (dir),
    .stage_in(stage_in),
    .thr_sel (thr_sel),
    .est_q   (est_q),
    .est_d   (est_d)
  );

  temp_est_trip #(
    .SEL_W(SEL_W), .STAGE_W(STAGE_W), .TEMP_W(TEMP_W),
    .FLOOR_MC(FLOOR_MC), .SEL_STEP_MC(SEL_STEP_MC),
    .STAGE_STEP_MC(STAGE_STEP_MC)
  ) u_trip (
    .thr_sel (thr_sel),
    .trips_mc(trips_mc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      est_q <= TEMP_W'(IDLE_MC);
      rec_q <= '0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= sample_go & differs;
      if (load_en) begin
        est_q <= est_d;
        rec_q <= stage_in;
      end
    end
  end

  assign est_mc        = est_q;
  assign rec_stage     = rec_q;
  assign stage_changed = chg_q;
  assign crit_mc       = trips_mc[(N_TRIP-1)*TEMP_W +: TEMP_W];

endmodule

// File: rtl/temp_est_chk.sv
module temp_est_chk #(
  parameter int STAGE_W = 2,
  parameter int TEMP_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_strobe,
  input logic               sample_strobe,
  input logic [STAGE_W-1:0] stage_in,
  input logic [STAGE_W-1:0] rec_stage,
  input logic [TEMP_W-1:0]  est_mc,
  input logic               stage_changed
);

  // R7: differing sample pulses the change flag
  a_r7_change_on_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !init_strobe && stage_in != rec_stage) |=> stage_changed);

  // R6: equal-stage sample holds the estimate, no pulse
  a_r6_hold_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !init_strobe && stage_in == rec_stage) |=> ($stable(est_mc) && !stage_changed));

  // R8: idle cycles change nothing
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_strobe && !init_strobe) |=> ($stable(est_mc) && $stable(rec_stage) && !stage_changed));

  // R3: init records the stage and never pulses
  a_r3_init_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_strobe |=> (!stage_changed && rec_stage == $past(stage_in)));

  // R9: never negative
  a_r9_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    !est_mc[TEMP_W-1]);

endmodule

bind die_temp_estimator temp_est_chk #(.STAGE_W(STAGE_W), .TEMP_W(TEMP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_strobe  (init_strobe),
  .sample_strobe(sample_strobe),
  .stage_in     (stage_in),
  .rec_stage    (rec_stage),
  .est_mc       (est_mc),
  .stage_changed(stage_changed)
);

// File: tb/test_die_temp_estimator.sv
module test_die_temp_estimator;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_strobe = 1'b0;
  logic        sample_strobe = 1'b0;
  logic [1:0]  stage_in = 2'd0;
  logic [1:0]  thr_sel = 2'd0;
  logic [31:0] est_mc;
  logic [1:0]  rec_stage;
  logic        stage_changed;
  logic [95:0] trips_mc;
  logic [31:0] crit_mc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  die_temp_estimator i_die_temp_estimator (
    .clk(clk), .rst_n(rst_n), .init_strobe(init_strobe),
    .sample_strobe(sample_strobe), .stage_in(stage_in), .thr_sel(thr_sel),
    .est_mc(est_mc), .rec_stage(rec_stage), .stage_changed(stage_changed),
    .trips_mc(trips_mc), .crit_mc(crit_mc)
  );

  function automatic int base_mc(int sel);
    return 105000 + sel * 5000;
  endfunction

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Pulse strobes for one rising edge; returns just after it at a falling edge.
  task automatic strobe(logic ini, logic smp, logic [1:0] st, logic [1:0] sel);
    @(negedge clk);
    init_strobe = ini; sample_strobe = smp; stage_in = st; thr_sel = sel;
    @(negedge clk);
    init_strobe = 1'b0; sample_strobe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e_init, e_move;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 est", int'(est_mc), 37000);
    chk("R1 rec", int'(rec_stage), 0);
    chk("R1 chg", int'(stage_changed), 0);

    for (int s = 0; s < 4; s++) begin
      thr_sel = 2'(s);
      #1;
      chk("R2 trip1", int'(trips_mc[31:0]), base_mc(s));
      chk("R2 trip2", int'(trips_mc[63:32]), base_mc(s) + 20000);
      chk("R2 trip3", int'(trips_mc[95:64]), base_mc(s) + 40000);
      chk("R2 crit", int'(crit_mc), base_mc(s) + 40000);
    end

    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int n = 0; n < 4; n++) begin
          strobe(1'b1, 1'b0, 2'(p), 2'(s));
          e_init = (p == 0) ? 37000 : base_mc(s) + (p - 1) * 20000;
          chk("R3 init est", int'(est_mc), e_init);
          chk("R3 init rec", int'(rec_stage), p);
          chk("R3 init chg", int'(stage_changed), 0);

          strobe(1'b0, 1'b1, 2'(n), 2'(s));
          if (n > p)      e_move = (n - 1) * 20000 + base_mc(s) + 2000;
          else if (n < p) e_move = n * 20000 + base_mc(s) - 2000;
          else            e_move = e_init;
          if (n > p)      chk("R4 rise est", int'(est_mc), e_move);
          else if (n < p) chk("R5 fall est", int'(est_mc), e_move);
          else            chk("R6 equal est", int'(est_mc), e_move);
          chk("R7 chg pulse", int'(stage_changed), (n != p) ? 1 : 0);
          chk("R7 rec load", int'(rec_stage), n);
          chk("R9 nonneg", int'(est_mc[31]), 0);

          @(negedge clk);
          chk("R7 pulse width", int'(stage_changed), 0);
          chk("R8 idle est", int'(est_mc), e_move);
          chk("R8 idle rec", int'(rec_stage), n);

          strobe(1'b0, 1'b1, 2'(n), 2'(s ^ 1));
          chk("R6 hold est", int'(est_mc), e_move);
          chk("R6 hold chg", int'(stage_changed), 0);
        end
      end
    end

    // R3 priority: init and sample together, sample alone would rise to 127000
    strobe(1'b1, 1'b0, 2'd0, 2'd0);
    strobe(1'b1, 1'b1, 2'd2, 2'd0);
    chk("R3 priority est", int'(est_mc), 125000);
    chk("R3 priority chg", int'(stage_changed), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule